// File: doc/BRIEF.md
# Serial Daisy-Chain Crosspoint Programmer

This block is the host-side engine that loads a chain of crosspoint switch devices through their shared serial port. The host presents a flat table holding, for every device and every output of that device, a source-select code and an enable bit. On a start request the block captures the table and serializes it onto one data line. It also generates the chain's serial clock, holds chip enable and the serial mode select asserted, and finally pulses the update strobe. That pulse moves the new routing into every device at the same moment.

The devices form a shift chain: device 0 sits nearest the host and device `NDEV-1` sits farthest away. Bits ripple through the nearer devices to reach the farther ones, so the stream begins with the farthest device. Within each device the stream runs from the highest output down to output 0. Each output occupies a 5-bit field. By default the field is sent as select bit 0 through select bit 3, then the enable bit. A parameter reverses this to enable first, then select bit 3 down to bit 0.

The serial clock is the system clock divided by `2*HALF_CYC`. The update pulse width is `UPD_CYC` system cycles. A start/busy/done handshake frames each transfer.

Top module: `xpt_chain_prog`

## Requirements
- R1: After reset and whenever idle: `sclk_o`=1, `ce_n_o`=1, `upd_n_o`=1, `mode_par_o`=1, `busy`=0 and `done`=0. `sdata_o` is 0 after reset.
- R2: Each accepted start produces exactly `NDEV*NOUT*5` falling edges on `sclk_o` (160 with the defaults) and no more.
- R3: The stream begins with all fields of device `NDEV-1` and ends with device 0. Device d's table entries are `cfg_sel[(d*NOUT+o)*SELW +: SELW]` and `cfg_en[d*NOUT+o]`.
- R4: Within one device, output `NOUT-1` is sent first and output 0 last. With the default ordering each field is sent as select bit 0, 1, 2, 3, then the enable bit.
- R5: `sdata_o` changes only in the cycle `sclk_o` rises, or in the cycle a start is accepted. The start-accept cycle is t0, the cycle after the edge that samples `start`. `sclk_o` is high for `HALF_CYC` cycles and then low for `HALF_CYC` cycles, so falling edge i of a transfer appears at cycle t0+(2i+1)*`HALF_CYC`.
- R6: `ce_n_o` and `mode_par_o` are low from cycle t0 through the cycle before `done` and high otherwise.
- R7: `upd_n_o` stays high throughout the shift. It is low for exactly `UPD_CYC` cycles, starting at cycle t0+2*`NDEV*NOUT*5`*`HALF_CYC`, when the serial clock returns high after the last falling edge.
- R8: `done` is high for exactly one cycle, one cycle after `upd_n_o` returns high. It coincides with `ce_n_o` being released high.
- R9: A `start` that is high while `busy` is high is ignored: it neither restarts nor extends the transfer.
- R10: `busy` is high from cycle t0 through the cycle before `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a chain load; sampled only while idle |
| cfg_sel | input | NDEV*NOUT*SELW | Source select per device and output |
| cfg_en | input | NDEV*NOUT | Output enable per device and output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock to the chain, idles high |
| sdata_o | output | 1 | Serial data to the first device |
| ce_n_o | output | 1 | Chip enable, active low |
| upd_n_o | output | 1 | Update strobe, active low |
| mode_par_o | output | 1 | Mode select: 0 serial, 1 parallel (idle) |

## Verification
Every result is due at a fixed offset from the start-accept cycle t0. Falling edge i is due at t0+(2i+1)*HALF_CYC. The update strobe is due low from t0+2*TOTAL*HALF_CYC for UPD_CYC cycles. Done is due one cycle after that window, with chip enable and busy released in the same cycle. The monitor detects t0 itself from `start` as sampled at the accepting edge. It then derives the expected level of every control line for each cycle from that offset. It compares on the falling system-clock edge, half a period away from the edge where the design updates. Each serial-clock fall pops the next expected bit from the queue the driver filled, so missing, extra or misordered bits all show up.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

   // sequencer phases
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_SHIFT = 2'd1,
      SEQ_UPD   = 2'd2,
      SEQ_REL   = 2'd3
   } seq_state_t;

   // one field per device output: select bits plus one enable bit
   function automatic int field_width(input int selw);
      return selw + 1;
   endfunction

endpackage

// File: rtl/xpt_stream_pack.sv
module xpt_stream_pack #(
   parameter int NDEV     = 2,
   parameter int NOUT     = 16,
   parameter int SELW     = 4,
   parameter bit D0_FIRST = 1'b1,
   localparam int FLD     = xpt_pkg::field_width(SELW),
   localparam int TOT     = NDEV * NOUT * FLD
) (
   input  logic [NDEV*NOUT*SELW-1:0] sel_flat,
   input  logic [NDEV*NOUT-1:0]      en_flat,
   output logic [TOT-1:0]            stream
);

   // stream[TOT-1] leaves first: farthest device, highest output first
   for (genvar d = 0; d < NDEV; d++) begin : g_dev
      for (genvar o = 0; o < NOUT; o++) begin : g_out
         localparam int BASE = ((NDEV-1-d)*NOUT + (NOUT-1-o)) * FLD;
         localparam int IDX  = d*NOUT + o;
         for (genvar k = 0; k < FLD; k++) begin : g_bit
            if (D0_FIRST) begin : g_lsb
               if (k < SELW) begin : g_sel
                  assign stream[TOT-1-BASE-k] = sel_flat[IDX*SELW + k];
               end else begin : g_en
                  assign stream[TOT-1-BASE-k] = en_flat[IDX];
               end
            end else begin : g_msb
               if (k == 0) begin : g_en
                  assign stream[TOT-1-BASE-k] = en_flat[IDX];
               end else begin : g_sel
                  assign stream[TOT-1-BASE-k] = sel_flat[IDX*SELW + SELW - k];
               end
            end
         end
      end
   end

endmodule

// File: rtl/xpt_sclk_div.sv
module xpt_sclk_div #(
   parameter int HALF_CYC = 2,
   localparam int CW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_evt
);

   logic [CW-1:0] cnt;
   logic          wrap;

   if (HALF_CYC < 1) begin : g_bad_half
      $error("HALF_CYC must be at least 1");
   end

   assign wrap     = run && (cnt == CW'(HALF_CYC-1));
   // low phase ending: the serial clock goes high at the next edge
   assign rise_evt = wrap && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b1;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b1;
      end else if (wrap) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   // R5: the serial clock only moves while a shift is running
   a_r5_idle_high : assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> sclk);

endmodule

// File: rtl/xpt_seq_ctl.sv
module xpt_seq_ctl
   import xpt_pkg::*;
#(
   parameter int TOT     = 160,
   parameter int UPD_CYC = 3,
   localparam int BCW    = (TOT > 1) ? $clog2(TOT) : 1,
   localparam int UCW    = (UPD_CYC > 1) ? $clog2(UPD_CYC) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [TOT-1:0] stream,
   input  logic           sclk,
   input  logic           rise_evt,
   output logic           run,
   output logic           ser_data,
   output logic           ce_n,
   output logic           upd_n,
   output logic           mode_par,
   output logic           busy,
   output logic           done
);

   if (TOT < 2) begin : g_bad_tot
      $error("stream must hold at least two bits");
   end
   if (UPD_CYC < 1) begin : g_bad_upd
      $error("UPD_CYC must be at least 1");
   end

   seq_state_t     state;
   logic [TOT-1:0] sreg;
   logic [BCW-1:0] bit_cnt;
   logic [UCW-1:0] ucnt;
   logic           last_bit;

   assign run      = (state == SEQ_SHIFT);
   assign busy     = (state != SEQ_IDLE);
   assign last_bit = (bit_cnt == BCW'(TOT-1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         sreg     <= '0;
         bit_cnt  <= '0;
         ucnt     <= '0;
         ser_data <= 1'b0;
         ce_n     <= 1'b1;
         upd_n    <= 1'b1;
         mode_par <= 1'b1;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state    <= SEQ_SHIFT;
                  sreg     <= stream;
                  ser_data <= stream[TOT-1];
                  bit_cnt  <= '0;
                  ce_n     <= 1'b0;
                  mode_par <= 1'b0;
               end
            end
            SEQ_SHIFT: begin
               if (rise_evt) begin
                  if (last_bit) begin
                     state <= SEQ_UPD;
                     upd_n <= 1'b0;
                     ucnt  <= '0;
                  end else begin
                     bit_cnt  <= bit_cnt + 1'b1;
                     sreg     <= {sreg[TOT-2:0], 1'b0};
                     ser_data <= sreg[TOT-2];
                  end
               end
            end
            SEQ_UPD: begin
               if (ucnt == UCW'(UPD_CYC-1)) begin
                  upd_n <= 1'b1;
                  state <= SEQ_REL;
               end else begin
                  ucnt <= ucnt + 1'b1;
               end
            end
            default: begin
               state    <= SEQ_IDLE;
               ce_n     <= 1'b1;
               mode_par <= 1'b1;
               done     <= 1'b1;
            end
         endcase
      end
   end

   // R5: data is steady across every capture edge of the chain
   a_r5_data_hold_at_fall : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> $stable(ser_data));

   // R6: the chain is selected in serial mode whenever its clock is low
   a_r6_selected_when_clocking : assert property (@(posedge clk) disable iff (!rst_n)
      !sclk |-> (!ce_n && !mode_par));

   // R7: update strobe only with the serial clock parked high
   a_r7_update_clock_parked : assert property (@(posedge clk) disable iff (!rst_n)
      !upd_n |-> (sclk && !ce_n));

   // R8: single-cycle completion, after the strobe has returned high
   a_r8_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_after_update : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(upd_n) && upd_n && ce_n));

   // R10: a transfer begins with the chain selected
   a_r10_busy_selects : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !ce_n);

endmodule

// File: rtl/xpt_chain_prog.sv
module xpt_chain_prog #(
   parameter int NDEV     = 2,
   parameter int NOUT     = 16,
   parameter int SELW     = 4,
   parameter int HALF_CYC = 2,
   parameter int UPD_CYC  = 3,
   parameter bit D0_FIRST = 1'b1,
   localparam int FLD     = xpt_pkg::field_width(SELW),
   localparam int TOT     = NDEV * NOUT * FLD
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NDEV*NOUT*SELW-1:0] cfg_sel,
   input  logic [NDEV*NOUT-1:0]      cfg_en,
   output logic                      busy,
   output logic                      done,
   output logic                      sclk_o,
   output logic                      sdata_o,
   output logic                      ce_n_o,
   output logic                      upd_n_o,
   output logic                      mode_par_o
);

   if (NDEV < 1) begin : g_bad_ndev
      $error("NDEV must be at least 1");
   end
   if (NOUT < 1 || SELW < 1) begin : g_bad_field
      $error("NOUT and SELW must be at least 1");
   end

   logic [TOT-1:0] stream;
   logic           run;
   logic           rise_evt;

   xpt_stream_pack #(
      .NDEV     (NDEV),
      .NOUT     (NOUT),
      .SELW     (SELW),
      .D0_FIRST (D0_FIRST)
   ) i_pack (
      .sel_flat (cfg_sel),
      .en_flat  (cfg_en),
      .stream   (stream)
   );

   xpt_sclk_div #(
      .HALF_CYC (HALF_CYC)
   ) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .sclk     (sclk_o),
      .rise_evt (rise_evt)
   );

   xpt_seq_ctl #(
      .TOT     (TOT),
      .UPD_CYC (UPD_CYC)
   ) i_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stream   (stream),
      .sclk     (sclk_o),
      .rise_evt (rise_evt),
      .run      (run),
      .ser_data (sdata_o),
      .ce_n     (ce_n_o),
      .upd_n    (upd_n_o),
      .mode_par (mode_par_o),
      .busy     (busy),
      .done     (done)
   );

endmodule

// File: tb/test_xpt_chain_prog.sv
`timescale 1ns/1ps
module test_xpt_chain_prog;

   localparam int NDEV  = 2;
   localparam int NOUT  = 16;
   localparam int SELW  = 4;
   localparam int HALF  = 2;
   localparam int UPDC  = 3;
   localparam int TOT   = NDEV * NOUT * (SELW + 1);
   localparam int SHEND = 2 * TOT * HALF;
   localparam int ENDC  = SHEND + UPDC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [NDEV*NOUT*SELW-1:0] cfg_sel = '0;
   logic [NDEV*NOUT-1:0]      cfg_en  = '0;
   logic busy, done, sclk_o, sdata_o, ce_n_o, upd_n_o, mode_par_o;

   always #2.5 clk = ~clk;

   xpt_chain_prog #(
      .NDEV (NDEV), .NOUT (NOUT), .SELW (SELW),
      .HALF_CYC (HALF), .UPD_CYC (UPDC), .D0_FIRST (1'b1)
   ) i_xpt_chain_prog (
      .clk (clk), .rst_n (rst_n), .start (start),
      .cfg_sel (cfg_sel), .cfg_en (cfg_en),
      .busy (busy), .done (done), .sclk_o (sclk_o), .sdata_o (sdata_o),
      .ce_n_o (ce_n_o), .upd_n_o (upd_n_o), .mode_par_o (mode_par_o)
   );

   int checks = 0;
   int fails  = 0;
   bit expq[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- driver ----------------
   function automatic logic [SELW-1:0] pat_sel(int seed, int d, int o);
      if (seed == 99) return '1;
      return SELW'((o*3 + d*5 + seed) % 16);
   endfunction
   function automatic logic pat_en(int seed, int d, int o);
      if (seed == 99) return 1'b1;
      return ((o + d + seed) % 3) != 0;
   endfunction

   // R3 R4: expected order is farthest device, highest output, sel0..sel3, enable
   task automatic load_table(input int seed);
      for (int d = 0; d < NDEV; d++)
         for (int o = 0; o < NOUT; o++) begin
            cfg_sel[(d*NOUT+o)*SELW +: SELW] = pat_sel(seed, d, o);
            cfg_en[d*NOUT+o] = pat_en(seed, d, o);
         end
      for (int d = NDEV-1; d >= 0; d--)
         for (int o = NOUT-1; o >= 0; o--) begin
            for (int b = 0; b < SELW; b++) expq.push_back(cfg_sel[(d*NOUT+o)*SELW + b]);
            expq.push_back(cfg_en[d*NOUT+o]);
         end
   endtask

   task automatic run_xfer(input int seed, input bit poke_busy);
      @(negedge clk);
      load_table(seed);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke_busy) begin
         // R9: a start pulse mid-transfer must be ignored
         repeat (100) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         repeat (ENDC - 100) @(negedge clk);
      end else begin
         repeat (ENDC) @(negedge clk);
      end
      repeat (10) @(negedge clk);
   endtask

   // ---------------- monitor ----------------
   logic st_prev = 1'b0;
   always @(posedge clk) st_prev <= start;

   int  ncyc = 0;
   int  t0 = 0;
   bit  active = 1'b0;
   bit  prev_busy_exp = 1'b0;
   int  bit_i = 0;
   logic prev_sclk = 1'b1;
   logic prev_data = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         int rel;
         bit eb, ul, de, sh;
         bit eb_bit;
         ncyc++;
         if (!prev_busy_exp && st_prev) begin
            t0 = ncyc; active = 1'b1; bit_i = 0;
         end
         rel = ncyc - t0;
         eb = active && (rel <= ENDC);
         ul = active && (rel >= SHEND) && (rel < SHEND + UPDC);
         de = active && (rel == ENDC + 1);
         sh = active && (rel < SHEND);
         chk({busy, ce_n_o, mode_par_o, upd_n_o, done} == {eb, !eb, !eb, !ul, de},
             eb ? "R6 R7 R8 R10" : "R1", "control {busy,ce_n,mode,upd_n,done}",
             int'({busy, ce_n_o, mode_par_o, upd_n_o, done}),
             int'({eb, !eb, !eb, !ul, de}));
         if (!sh) chk(sclk_o == 1'b1, "R1 R7", "sclk parked high", sclk_o, 1);
         // falling serial clock: the chain captures here
         if (prev_sclk && !sclk_o) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R2", "extra falling edge, bit index", bit_i, TOT);
            end else begin
               eb_bit = expq.pop_front();
               chk(sdata_o == eb_bit, "R3 R4", $sformatf("bit %0d value", bit_i),
                   sdata_o, eb_bit);
            end
            chk(ncyc == t0 + (2*bit_i + 1)*HALF, "R5", "falling edge cycle",
                ncyc, t0 + (2*bit_i + 1)*HALF);
            bit_i++;
         end
         if (sdata_o !== prev_data)
            chk((sclk_o && !prev_sclk) || (active && rel == 0), "R5",
                "data change outside rising edge", ncyc, t0);
         if (de) begin
            chk(bit_i == TOT, "R2", "falling edges in transfer", bit_i, TOT);
            chk(expq.size() == 0, "R2", "bits left unsent", expq.size(), 0);
         end
         prev_busy_exp = eb;
         prev_sclk = sclk_o;
         prev_data = sdata_o;
      end
   end

   // ---------------- main ----------------
   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk({sclk_o, sdata_o, ce_n_o, upd_n_o, mode_par_o, busy, done} == 7'b1011100,
          "R1", "reset outputs",
          int'({sclk_o, sdata_o, ce_n_o, upd_n_o, mode_par_o, busy, done}), 7'b1011100);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_xfer(0, 1'b0);
      run_xfer(7, 1'b1);
      // R9: nothing restarted after the ignored request
      chk(busy == 1'b0, "R9", "busy after ignored start", busy, 0);
      run_xfer(99, 1'b0);
      repeat (20) @(negedge clk);
      chk(busy == 1'b0 && ce_n_o == 1'b1, "R1", "idle after last transfer",
          int'({busy, ce_n_o}), 1);
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule